// File: doc/BRIEF.md
# Clock-Crossing Memory Request Bridge

This block moves one memory access at a time from a fast processor clock domain to a slower DRAM controller user port, and then returns the result. Each side runs its own state machine and publishes a two-bit phase code. The other side samples that code only through a chain of synchronizer flops in its own clock domain. Request fields and returned read data are never synchronized bit by bit. They are held in registers, and the far side reads them only while the published phases show that those registers are frozen.

The processor presents a byte address, 32-bit store data, an access size and a one-cycle request strobe. The controller port is addressed in 16-bit units and carries 128-bit data with a 16-bit byte mask. Stores of one, two or four naturally aligned bytes therefore become a single masked line write, with no read-modify-write. A down-counter on a reference clock holds the controller and the bridge in reset after power-up. No command leaves the bridge until the controller reports that calibration has finished.

Top module: `mbridge_top`

## Requirements
- R1: While `ext_rst_n` is low, and for exactly RST_CYCLES rising edges of `ref_clk` after it goes high, `mem_ctrl_rst` is high. A `cpu_req` given during that time is dropped: it produces no command and no `cpu_done`.
- R2: `mem_cmd_valid` never rises unless `mem_calib_done` was high in the previous `mem_clk` cycle. A request made before calibration waits and completes once calibration is reported.
- R3: The command address is the processor byte address shifted right by one. The opcode is 3'b000 for a write and 3'b001 for a read.
- R4: Size codes are 2'b00 for one byte, 2'b01 for two bytes, and 2'b10 or 2'b11 for four bytes. The lane offset is `cpu_addr[3:0]` with the low bits below the access size cleared. Store byte k goes to line byte offset+k. A mask bit of 1 means the byte is not written, so exactly 1, 2 or 4 mask bits are 0. A write raises `mem_wr_valid` in the same cycle as its command.
- R5: A read returns line bytes offset..offset+n-1 on `cpu_rdata` in little-endian order, zero-extended above n bytes.
- R6: A command is held unchanged until it is accepted with `mem_cmd_ready`. Write data and mask are held unchanged until accepted with `mem_wr_ready`. The two handshakes may complete in either order.
- R7: `cpu_done` is a pulse of exactly one `cpu_clk` cycle. `cpu_rdata` is valid from that cycle until the next read completes.
- R8: Only one access is outstanding. `cpu_idle` is low from acceptance until the memory side has returned to idle. A `cpu_req` while `cpu_idle` is low is ignored and issues no command. Each access issues exactly one command.
- R9: Each published phase code changes in at most one bit per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the reset counter |
| ext_rst_n | input | 1 | External active-low reset |
| mem_ctrl_rst | output | 1 | Reset to the memory controller, held by the counter |
| cpu_clk | input | 1 | Processor clock |
| cpu_req | input | 1 | One-cycle request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_rdata | output | 32 | Read result |
| cpu_done | output | 1 | Completion pulse |
| cpu_idle | output | 1 | Bridge can accept a request |
| mem_clk | input | 1 | Controller user clock |
| mem_calib_done | input | 1 | Controller calibration finished |
| mem_cmd_valid | output | 1 | Command valid |
| mem_cmd_op | output | 3 | Command opcode |
| mem_cmd_addr | output | ADDR_W-1 | 16-bit-unit address |
| mem_cmd_ready | input | 1 | Controller accepts command |
| mem_wr_valid | output | 1 | Write data valid |
| mem_wr_last | output | 1 | Last (only) write beat |
| mem_wr_data | output | 128 | Write line |
| mem_wr_mask | output | 16 | Byte mask, 1 = skip byte |
| mem_wr_ready | input | 1 | Controller accepts write data |
| mem_rd_valid | input | 1 | Read line valid |
| mem_rd_data | input | 128 | Read line |

## Verification
The bench builds the bridge with ADDR_W=12, RST_CYCLES=40 and SYNC_STAGES=3. The short reset count lets the exact release edge be counted within a few hundred cycles. Three synchronizer stages lengthen both legs of the phase exchange. The stray-request check uses that longer window, and a memory model with random ready throttling leaves commands and write data pending across many cycles. The controller clock is not a whole multiple of the processor clock, so phase changes land at varying points in the other domain.

// File: rtl/mbridge_pkg.sv
`timescale 1ns/1ps
package mbridge_pkg;
    // published phase codes: a Gray cycle so a sampled code is never a blend
    localparam logic [1:0] PH_IDLE = 2'b00;
    localparam logic [1:0] PH_WORK = 2'b01;
    localparam logic [1:0] PH_DONE = 2'b11;
    localparam logic [1:0] PH_BACK = 2'b10;

    localparam logic [2:0] OP_WRITE = 3'b000;
    localparam logic [2:0] OP_READ  = 3'b001;

    localparam int LINE_W  = 128;
    localparam int LANES   = LINE_W / 8;

    function automatic logic [3:0] size_en(input logic [1:0] sz);
        case (sz)
            2'b00:   return 4'b0001;
            2'b01:   return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [3:0] lane_of(input logic [3:0] lo, input logic [1:0] sz);
        case (sz)
            2'b00:   return lo;
            2'b01:   return {lo[3:1], 1'b0};
            default: return {lo[3:2], 2'b00};
        endcase
    endfunction

    function automatic logic [LANES-1:0] mask_of(input logic [1:0] sz, input logic [3:0] off);
        logic [LANES-1:0] en;
        en = {12'd0, size_en(sz)} << off;
        return ~en;
    endfunction

    function automatic logic [LINE_W-1:0] place(input logic [31:0] w, input logic [3:0] off);
        return {96'd0, w} << {off, 3'b000};
    endfunction

    function automatic logic [31:0] pick(input logic [LINE_W-1:0] line, input logic [3:0] off,
                                         input logic [1:0] sz);
        logic [LINE_W-1:0] s;
        s = line >> {off, 3'b000};
        case (sz)
            2'b00:   return {24'd0, s[7:0]};
            2'b01:   return {16'd0, s[15:0]};
            default: return s[31:0];
        endcase
    endfunction
endpackage

// File: rtl/mbridge_rstgen.sv
`timescale 1ns/1ps
module mbridge_rstgen #(
    parameter int RST_CYCLES = 4000
) (
    input  logic ref_clk,
    input  logic ext_rst_n,
    output logic rst_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    end

    always_ff @(posedge ref_clk or negedge ext_rst_n) begin
        if (!ext_rst_n) cnt_q <= CW'(RST_CYCLES);
        else            cnt_q <= cnt_d;
    end

    assign rst_o = (cnt_q != '0);

    // R1: once counting, the hold never re-arms without the external reset
    assert_no_rearm_R1: assert property (@(posedge ref_clk) disable iff (!ext_rst_n)
        !rst_o |=> !rst_o);
endmodule

// File: rtl/mbridge_sync.sv
`timescale 1ns/1ps
module mbridge_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) stg_q <= {STAGES*W{RST_VAL}};
        else     stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbridge_cpu_side.sv
`timescale 1ns/1ps
module mbridge_cpu_side
    import mbridge_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_idle,
    input  logic [1:0]        peer_code,
    input  logic [31:0]       peer_rdata,
    output logic [1:0]        pub_code,
    output logic              req_we,
    output logic [1:0]        req_size,
    output logic [ADDR_W-1:0] req_addr,
    output logic [31:0]       req_wdata
);
    typedef enum logic [1:0] {C_IDLE, C_REQ, C_FIN, C_BACK} cpu_st_e;

    typedef struct packed {
        cpu_st_e           st;
        logic              we;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic [31:0]       rdata;
        logic              done;
    } cpu_regs_t;

    cpu_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            C_IDLE: if (cpu_req) begin
                r_d.we    = cpu_we;
                r_d.size  = cpu_size;
                r_d.addr  = cpu_addr;
                r_d.wdata = cpu_wdata;
                r_d.st    = C_REQ;
            end
            C_REQ: if (peer_code == PH_DONE) begin
                if (!r_q.we) r_d.rdata = peer_rdata;
                r_d.done = 1'b1;
                r_d.st   = C_FIN;
            end
            C_FIN:  if (peer_code == PH_IDLE) r_d.st = C_BACK;
            default: r_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        case (r_q.st)
            C_IDLE:  pub_code = PH_IDLE;
            C_REQ:   pub_code = PH_WORK;
            C_FIN:   pub_code = PH_DONE;
            default: pub_code = PH_BACK;
        endcase
    end

    assign cpu_rdata = r_q.rdata;
    assign cpu_done  = r_q.done;
    assign cpu_idle  = (r_q.st == C_IDLE);
    assign req_we    = r_q.we;
    assign req_size  = r_q.size;
    assign req_addr  = r_q.addr;
    assign req_wdata = r_q.wdata;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);
    assert_fields_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !cpu_idle |=> (cpu_idle || ($stable(req_addr) && $stable(req_we) && $stable(req_wdata))));
    assert_gray_cpu_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(pub_code ^ $past(pub_code)) <= 1);
endmodule

// File: rtl/mbridge_mem_side.sv
`timescale 1ns/1ps
module mbridge_mem_side
    import mbridge_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              calib,
    input  logic [1:0]        peer_code,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [1:0]        pub_code,
    output logic [31:0]       rdata_o,
    output logic              mem_cmd_valid,
    output logic [2:0]        mem_cmd_op,
    output logic [ADDR_W-2:0] mem_cmd_addr,
    input  logic              mem_cmd_ready,
    output logic              mem_wr_valid,
    output logic              mem_wr_last,
    output logic [LINE_W-1:0] mem_wr_data,
    output logic [LANES-1:0]  mem_wr_mask,
    input  logic              mem_wr_ready,
    input  logic              mem_rd_valid,
    input  logic [LINE_W-1:0] mem_rd_data
);
    typedef enum logic [2:0] {M_IDLE, M_ISSUE, M_RDWAIT, M_DONE, M_BACK} mem_st_e;

    typedef struct packed {
        mem_st_e           st;
        logic              we;
        logic [ADDR_W-2:0] addr;
        logic [3:0]        off;
        logic [1:0]        size;
        logic              cmd_pend;
        logic              wr_pend;
        logic [LINE_W-1:0] line;
        logic [LANES-1:0]  mask;
        logic [31:0]       rdata;
    } mem_regs_t;

    mem_regs_t r_d, r_q;
    logic      cmd_left, wr_left;

    always_comb begin
        r_d      = r_q;
        cmd_left = r_q.cmd_pend && !mem_cmd_ready;
        wr_left  = r_q.wr_pend && !mem_wr_ready;
        case (r_q.st)
            M_IDLE: if (calib && peer_code == PH_WORK) begin
                r_d.we       = req_we;
                r_d.addr     = req_addr[ADDR_W-1:1];
                r_d.size     = req_size;
                r_d.off      = lane_of(req_addr[3:0], req_size);
                r_d.line     = place(req_wdata, lane_of(req_addr[3:0], req_size));
                r_d.mask     = mask_of(req_size, lane_of(req_addr[3:0], req_size));
                r_d.cmd_pend = 1'b1;
                r_d.wr_pend  = req_we;
                r_d.st       = M_ISSUE;
            end
            M_ISSUE: begin
                r_d.cmd_pend = cmd_left;
                r_d.wr_pend  = wr_left;
                if (!cmd_left && !wr_left) r_d.st = r_q.we ? M_DONE : M_RDWAIT;
            end
            M_RDWAIT: if (mem_rd_valid) begin
                r_d.rdata = pick(mem_rd_data, r_q.off, r_q.size);
                r_d.st    = M_DONE;
            end
            M_DONE:  if (peer_code == PH_DONE) r_d.st = M_BACK;
            default: r_d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        case (r_q.st)
            M_IDLE:             pub_code = PH_IDLE;
            M_ISSUE, M_RDWAIT:  pub_code = PH_WORK;
            M_DONE:             pub_code = PH_DONE;
            default:            pub_code = PH_BACK;
        endcase
    end

    assign rdata_o       = r_q.rdata;
    assign mem_cmd_valid = (r_q.st == M_ISSUE) && r_q.cmd_pend;
    assign mem_cmd_op    = r_q.we ? OP_WRITE : OP_READ;
    assign mem_cmd_addr  = r_q.addr;
    assign mem_wr_valid  = (r_q.st == M_ISSUE) && r_q.wr_pend;
    assign mem_wr_last   = mem_wr_valid;
    assign mem_wr_data   = r_q.line;
    assign mem_wr_mask   = r_q.mask;

    assert_calib_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cmd_valid) |-> $past(calib));
    assert_wr_with_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_cmd_valid) && mem_cmd_op == OP_WRITE) |-> mem_wr_valid);
    assert_mask_bytes_R4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> ($countones(~mem_wr_mask) == 1 || $countones(~mem_wr_mask) == 2 ||
                          $countones(~mem_wr_mask) == 4));
    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !mem_cmd_ready) |=>
        (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_op)));
    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
        (mem_wr_valid && $stable(mem_wr_data) && $stable(mem_wr_mask)));
    assert_single_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_ready) |=> !mem_cmd_valid);
    assert_gray_mem_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(pub_code ^ $past(pub_code)) <= 1);
endmodule

// File: rtl/mbridge_top.sv
`timescale 1ns/1ps
module mbridge_top
    import mbridge_pkg::*;
#(
    parameter int ADDR_W      = 28,
    parameter int RST_CYCLES  = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              ext_rst_n,
    output logic              mem_ctrl_rst,
    input  logic              cpu_clk,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_idle,
    input  logic              mem_clk,
    input  logic              mem_calib_done,
    output logic              mem_cmd_valid,
    output logic [2:0]        mem_cmd_op,
    output logic [ADDR_W-2:0] mem_cmd_addr,
    input  logic              mem_cmd_ready,
    output logic              mem_wr_valid,
    output logic              mem_wr_last,
    output logic [127:0]      mem_wr_data,
    output logic [15:0]       mem_wr_mask,
    input  logic              mem_wr_ready,
    input  logic              mem_rd_valid,
    input  logic [127:0]      mem_rd_data
);
    logic              rst_raw, cpu_rst, mem_rst;
    logic [1:0]        cpu_code, mem_code, cpu_code_at_mem, mem_code_at_cpu;
    logic              req_we;
    logic [1:0]        req_size;
    logic [ADDR_W-1:0] req_addr;
    logic [31:0]       req_wdata, mem_rdata;

    mbridge_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
        .ref_clk(ref_clk), .ext_rst_n(ext_rst_n), .rst_o(rst_raw));

    assign mem_ctrl_rst = rst_raw;

    mbridge_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cpu_rst (
        .clk(cpu_clk), .rst(rst_raw), .d(1'b0), .q(cpu_rst));
    mbridge_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mem_rst (
        .clk(mem_clk), .rst(rst_raw), .d(1'b0), .q(mem_rst));

    mbridge_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_to_mem (
        .clk(mem_clk), .rst(mem_rst), .d(cpu_code), .q(cpu_code_at_mem));
    mbridge_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_to_cpu (
        .clk(cpu_clk), .rst(cpu_rst), .d(mem_code), .q(mem_code_at_cpu));

    mbridge_cpu_side #(.ADDR_W(ADDR_W)) u_cpu (
        .clk(cpu_clk), .rst(cpu_rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_idle(cpu_idle),
        .peer_code(mem_code_at_cpu), .peer_rdata(mem_rdata), .pub_code(cpu_code),
        .req_we(req_we), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata));

    mbridge_mem_side #(.ADDR_W(ADDR_W)) u_mem (
        .clk(mem_clk), .rst(mem_rst), .calib(mem_calib_done),
        .peer_code(cpu_code_at_mem), .req_we(req_we), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .pub_code(mem_code), .rdata_o(mem_rdata),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_op(mem_cmd_op), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_ready(mem_cmd_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_last(mem_wr_last),
        .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask), .mem_wr_ready(mem_wr_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data));
endmodule

// File: tb/mbridge_top_bench.sv
`timescale 1ns/1ps
module mbridge_top_bench;
    localparam int AW = 12;
    localparam int RC = 40;

    logic ref_clk = 0, cpu_clk = 0, mem_clk = 0;
    always #5   ref_clk = ~ref_clk;
    always #2.5 cpu_clk = ~cpu_clk;
    always #6   mem_clk = ~mem_clk;

    logic          ext_rst_n, mem_ctrl_rst;
    logic          cpu_req, cpu_we, cpu_done, cpu_idle;
    logic [1:0]    cpu_size;
    logic [AW-1:0] cpu_addr;
    logic [31:0]   cpu_wdata, cpu_rdata;
    logic          mem_calib_done, mem_cmd_valid, mem_cmd_ready;
    logic [2:0]    mem_cmd_op;
    logic [AW-2:0] mem_cmd_addr;
    logic          mem_wr_valid, mem_wr_last, mem_wr_ready, mem_rd_valid;
    logic [127:0]  mem_wr_data, mem_rd_data;
    logic [15:0]   mem_wr_mask;

    mbridge_top #(.ADDR_W(AW), .RST_CYCLES(RC), .SYNC_STAGES(3)) u_mbridge_top (.*);

    typedef struct { logic [2:0] op; logic [AW-2:0] addr; } cmd_exp_t;
    typedef struct { logic [127:0] data; logic [15:0] mask; int base; } wr_exp_t;

    cmd_exp_t   cmd_q[$];
    wr_exp_t    wr_q[$];
    logic [7:0] shadow [256];
    logic [7:0] model  [256];
    int checks = 0, errors = 0, uncal_cmds = 0, rd_cnt = 0, rd_base = 0;
    bit mon_on = 0, hold_c = 0, hold_w = 0, prev_cv = 0;
    logic [AW-2:0] hold_addr;
    logic [2:0]    hold_op;
    logic [127:0]  hold_data;
    logic [15:0]   hold_mask;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model and monitor: all sampling and driving at the falling edge
    always @(negedge mem_clk) begin
        if (mon_on) begin
            if (!mem_calib_done && mem_cmd_valid) uncal_cmds++;
            if (hold_c) check(mem_cmd_valid && mem_cmd_addr == hold_addr && mem_cmd_op == hold_op,
                              "R6 command held", {mem_cmd_valid, mem_cmd_addr}, {1'b1, hold_addr});
            if (hold_w) check(mem_wr_valid && mem_wr_data == hold_data && mem_wr_mask == hold_mask,
                              "R6 write data held", mem_wr_mask, hold_mask);
            if (mem_cmd_valid && !prev_cv && mem_cmd_op == 3'b000)
                check(mem_wr_valid, "R4 write data with command", mem_wr_valid, 1);
        end
        prev_cv = mem_cmd_valid;
        mem_rd_valid = 1'b0;
        if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
                mem_rd_valid = 1'b1;
                for (int i = 0; i < 16; i++) mem_rd_data[8*i +: 8] = model[rd_base + i];
            end
        end
        mem_cmd_ready = ($urandom % 3) != 0;
        mem_wr_ready  = ($urandom % 4) != 0;
        hold_c = mon_on && mem_cmd_valid && !mem_cmd_ready;
        hold_w = mon_on && mem_wr_valid && !mem_wr_ready;
        hold_addr = mem_cmd_addr; hold_op = mem_cmd_op;
        hold_data = mem_wr_data;  hold_mask = mem_wr_mask;
        if (mon_on && mem_cmd_valid && mem_cmd_ready) begin
            if (cmd_q.size() == 0) check(0, "R8 unexpected command", mem_cmd_addr, 0);
            else begin
                cmd_exp_t e;
                e = cmd_q.pop_front();
                check(mem_cmd_op == e.op, "R3 opcode", mem_cmd_op, e.op);
                check(mem_cmd_addr == e.addr, "R3 address", mem_cmd_addr, e.addr);
            end
            if (mem_cmd_op == 3'b001) begin
                rd_cnt  = 3;
                rd_base = int'({mem_cmd_addr, 1'b0}) & ~15 & 255;
            end
        end
        if (mon_on && mem_wr_valid && mem_wr_ready) begin
            if (wr_q.size() == 0) check(0, "R8 unexpected write data", mem_wr_mask, 0);
            else begin
                wr_exp_t w;
                w = wr_q.pop_front();
                check(mem_wr_mask == w.mask, "R4 byte mask", mem_wr_mask, w.mask);
                for (int i = 0; i < 16; i++)
                    if (!w.mask[i])
                        check(mem_wr_data[8*i +: 8] == w.data[8*i +: 8], "R4 lane data",
                              mem_wr_data[8*i +: 8], w.data[8*i +: 8]);
                for (int i = 0; i < 16; i++)
                    if (!mem_wr_mask[i]) model[w.base + i] = mem_wr_data[8*i +: 8];
            end
        end
    end

    task automatic do_access(input bit we, input logic [1:0] sz, input int a,
                             input logic [31:0] wd, input bit stray);
        int nb, n;
        logic [31:0] exp_r;
        cmd_exp_t ce;
        wr_exp_t  we_e;
        nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        ce.op   = we ? 3'b000 : 3'b001;
        ce.addr = (AW-1)'(a >> 1);
        cmd_q.push_back(ce);
        exp_r = '0;
        for (int k = 0; k < nb; k++) exp_r[8*k +: 8] = shadow[a + k];
        if (we) begin
            we_e.mask = '1; we_e.data = '0; we_e.base = a & ~15;
            for (int k = 0; k < nb; k++) begin
                we_e.mask[(a & 15) + k] = 1'b0;
                we_e.data[8*((a & 15) + k) +: 8] = wd[8*k +: 8];
                shadow[a + k] = wd[8*k +: 8];
            end
            wr_q.push_back(we_e);
        end
        n = 0;
        while (!cpu_idle && n < 5000) begin @(negedge cpu_clk); n++; end
        cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = AW'(a); cpu_wdata = wd;
        @(negedge cpu_clk);
        cpu_req = 0;
        if (stray) begin
            repeat (2) @(negedge cpu_clk);
            check(!cpu_idle, "R8 busy while outstanding", cpu_idle, 0);
            cpu_req = 1; cpu_we = ~we; cpu_addr = AW'(a ^ 64); cpu_wdata = ~wd;
            @(negedge cpu_clk);
            cpu_req = 0;
        end
        n = 0;
        while (!cpu_done && n < 5000) begin @(negedge cpu_clk); n++; end
        if (n >= 5000) check(0, "R7 completion missing", 0, 1);
        else begin
            if (!we) check(cpu_rdata == exp_r, "R5 read data", cpu_rdata, exp_r);
            @(negedge cpu_clk);
            check(!cpu_done, "R7 single-cycle done", cpu_done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge cpu_clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        for (int i = 0; i < 256; i++) begin
            shadow[i] = 8'(i * 7 + 3);
            model[i]  = 8'(i * 7 + 3);
        end
        cpu_req = 0; cpu_we = 0; cpu_size = 0; cpu_addr = 0; cpu_wdata = 0;
        mem_calib_done = 0; mem_rd_data = '0; mem_rd_valid = 0;
        mem_cmd_ready = 0; mem_wr_ready = 0;
        ext_rst_n = 1;
        #2 ext_rst_n = 0;
        repeat (5) @(negedge cpu_clk);
        cpu_req = 1; cpu_addr = 12'h080;
        @(negedge cpu_clk);
        cpu_req = 0;
        repeat (20) @(negedge ref_clk);
        check(mem_ctrl_rst == 1, "R1 controller reset held", mem_ctrl_rst, 1);
        check(!cpu_done && !mem_cmd_valid && !mem_wr_valid, "R1 outputs quiet in reset",
              {cpu_done, mem_cmd_valid, mem_wr_valid}, 0);
        ext_rst_n = 1;
        k = 0;
        do begin @(negedge ref_clk); k++; end while (mem_ctrl_rst && k < 1000);
        check(k == RC, "R1 reset hold length", k, RC);
        mon_on = 1;
        repeat (40) @(negedge cpu_clk);
        check(cpu_idle && !cpu_done, "R1 request in reset dropped", {cpu_idle, cpu_done}, 2'b10);

        fork
            begin
                repeat (60) @(negedge mem_clk);
                check(uncal_cmds == 0, "R2 no command before calibration", uncal_cmds, 0);
                mem_calib_done = 1;
            end
        join_none
        do_access(1, 2'b10, 'h10, 32'hCAFE_F00D, 0);
        check(mem_calib_done == 1, "R2 completion after calibration", mem_calib_done, 1);

        do_access(1, 2'b10, 'h20, 32'hA1B2_C3D4, 0);
        do_access(1, 2'b01, 'h26, 32'h0000_5566, 0);
        do_access(1, 2'b00, 'h2B, 32'hFFFF_FF77, 0);
        do_access(1, 2'b00, 'h3F, 32'h0000_00EE, 0);
        do_access(0, 2'b10, 'h20, 0, 0);
        do_access(0, 2'b00, 'h21, 0, 0);
        do_access(0, 2'b01, 'h22, 0, 0);
        do_access(0, 2'b00, 'h2B, 0, 0);
        do_access(0, 2'b01, 'h26, 0, 0);
        do_access(0, 2'b10, 'h24, 0, 0);
        do_access(0, 2'b10, 'h3C, 0, 0);
        do_access(0, 2'b10, 'h10, 0, 0);
        do_access(0, 2'b00, 'h3F, 0, 0);
        do_access(0, 2'b10, 'h30, 0, 1);
        do_access(1, 2'b01, 'h52, 32'h0000_1234, 1);
        do_access(0, 2'b01, 'h52, 0, 0);

        for (int it = 0; it < 40; it++) begin
            logic [1:0] sz;
            int nb, a;
            sz = 2'($urandom % 3);
            nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
            a  = int'($urandom % 256) & ~(nb - 1);
            do_access(1'($urandom % 2), sz, a, $urandom, 0);
        end

        repeat (60) @(negedge cpu_clk);
        check(cmd_q.size() == 0 && wr_q.size() == 0, "R8 one command per access",
              cmd_q.size() + wr_q.size(), 0);
        check(cpu_idle, "R8 idle at rest", cpu_idle, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule